// File: doc/BRIEF.md
# Timer Compare/Capture Channel

This block is one general register channel attached to a free-running up-counter. A 4-bit mode code, written through a one-cycle write strobe, selects one of two kinds of behaviour. In the output-compare modes the code sets the pin's starting level and the action taken on the pin each time the counter equals the general register. In the input-capture modes the code makes the channel copy the counter into the general register, either on a chosen edge of the synchronized pin input or on each count event of a second, cascaded counter.

Behaviour is organised around a four-state mode machine. The states are `ST_OC_OFF` (output compare, pin not driven: codes 0000 and 0100), `ST_OC_DRIVE` (output compare, pin driven: codes 0001-0011 and 0101-0111), `ST_CAP_PIN` (capture on pin edges: codes 10xx) and `ST_CAP_CASC` (capture on cascaded count events: codes 11xx). There is one transition for each state: a mode write moves the machine into the state that the written code decodes to, from any state, and with no write the state holds. Every match or capture raises a one-cycle event pulse and sets a sticky flag that a write-one clear removes. A buffer-mode input silences the channel completely, and a fast-clock input blocks cascaded captures.

Top module: `tcc_channel`

## Requirements
- R1: After reset the mode code is 0000, the counter and general register are zero, the pin output and its enable are low, and both event outputs are low.
- R2: A mode write with bit 3 clear loads the pin level from bit 2 of the code (0 low, 1 high). The new level appears on `pin_out` in the cycle after the write.
- R3: `pin_oe` is high in the cycle after a write of code 0001, 0010, 0011, 0101, 0110 or 0111. It is low after a write of 0000, 0100 or any code with bit 3 set.
- R4: A compare match occurs in an output-compare mode when `cnt_en` is high and the counter equals the general register. At the next edge the pin acts on code bits [1:0]: 00 no change, 01 low, 10 high, 11 toggle. The event pulse rises at that same edge, and the counter has then already moved one past the register value.
- R5: The counter increments by one on each clock while `cnt_en` is high and holds while it is low.
- R6: Code 1000 captures the counter into the general register on a rising pin edge. Code 1001 does the same on a falling edge. The opposite edge leaves the register unchanged. A pin change becomes visible in the register three clock edges after it happens, because of the two-flop synchronizer and the previous-sample flop.
- R7: Codes 1010 and 1011 capture on both rising and falling pin edges.
- R8: Codes 11xx capture on the clock edge after `cas_up` or `cas_dn` is seen high, and pin edges do nothing. While `cas_fast` is high, no cascaded capture occurs.
- R9: While `buf_mode` is high, compare matches and captures are both suppressed: the pin level and the general register keep their values, and no event is flagged.
- R10: `evt_pulse` is high for exactly one cycle per event. `evt_sticky` stays set until `flag_clr` is high. When a clear and a new event arrive in the same cycle, the event wins.
- R11: When a capture and a `gr_we` write fall in the same cycle, the register takes the captured counter value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mode code write strobe |
| cfg_wdata | input | 4 | Mode code |
| gr_we | input | 1 | General register write strobe |
| gr_wdata | input | CNT_W | General register write data |
| cnt_en | input | 1 | Counter enable |
| flag_clr | input | 1 | Write-one clear of the sticky event flag |
| buf_mode | input | 1 | Register used as a buffer: suppress all events |
| cas_up | input | 1 | Cascaded counter up-count event |
| cas_dn | input | 1 | Cascaded counter down-count event |
| cas_fast | input | 1 | Cascaded counter clocked at the undivided clock: block cascaded capture |
| pin_in | input | 1 | Asynchronous pin input |
| pin_out | output | 1 | Pin output level |
| pin_oe | output | 1 | Pin output enable |
| gr_q | output | CNT_W | General register value |
| cnt_q | output | CNT_W | Counter value |
| evt_pulse | output | 1 | One-cycle match/capture event |
| evt_sticky | output | 1 | Sticky match/capture flag |

## Verification
Two pairs of functions can land in the same cycle. One pair is a cascaded capture and a software write to the general register. The bench raises `cas_up` and `gr_we` together, with write data that differs from the frozen counter, and it passes only if the register then shows the counter value. The other pair is a flag clear and a new event: `flag_clr` is raised in the same cycle as a capture trigger, and the sticky flag must still read one afterwards.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    typedef enum logic [1:0] {
        ST_OC_OFF   = 2'd0,
        ST_OC_DRIVE = 2'd1,
        ST_CAP_PIN  = 2'd2,
        ST_CAP_CASC = 2'd3
    } tcc_state_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } tcc_act_e;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_BOTH = 2'd2
    } tcc_edge_e;

    function automatic tcc_state_e tcc_decode(input logic [3:0] code);
        if (code[3]) begin
            return code[2] ? ST_CAP_CASC : ST_CAP_PIN;
        end
        return (code[1:0] == 2'b00) ? ST_OC_OFF : ST_OC_DRIVE;
    endfunction

endpackage

// File: rtl/tcc_pin_sync.sv
module tcc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q[0] <= 1'b0;
        end else begin
            sync_q[0] <= pin_in;
        end
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q[g] <= 1'b0;
                end else begin
                    sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;
    assign fall = ~sync_q[STAGES-1] & prev_q;

endmodule

// File: rtl/tcc_mode_fsm.sv
module tcc_mode_fsm
    import tcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [3:0] cfg_wdata,
    output tcc_state_e state,
    output tcc_act_e   action,
    output tcc_edge_e  edge_sel,
    output logic       is_oc,
    output logic       oe
);
    tcc_state_e state_q, state_d;
    logic [1:0] low_q;

    always_comb begin
        state_d = state_q;
        if (cfg_we) begin
            state_d = tcc_decode(cfg_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OC_OFF;
            low_q   <= 2'b00;
        end else begin
            state_q <= state_d;
            if (cfg_we) begin
                low_q <= cfg_wdata[1:0];
            end
        end
    end

    always_comb begin
        is_oc    = 1'b0;
        oe       = 1'b0;
        action   = ACT_NONE;
        edge_sel = EDGE_RISE;
        unique case (state_q)
            ST_OC_OFF: begin
                is_oc = 1'b1;
            end
            ST_OC_DRIVE: begin
                is_oc  = 1'b1;
                oe     = 1'b1;
                action = tcc_act_e'(low_q);
            end
            ST_CAP_PIN: begin
                edge_sel = low_q[1] ? EDGE_BOTH :
                           (low_q[0] ? EDGE_FALL : EDGE_RISE);
            end
            ST_CAP_CASC: begin
                edge_sel = EDGE_RISE;
            end
            default: begin
                is_oc = 1'b0;
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/tcc_core.sv
module tcc_core
    import tcc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tcc_state_e       state,
    input  tcc_act_e         action,
    input  tcc_edge_e        edge_sel,
    input  logic             is_oc,
    input  logic             init_load,
    input  logic             init_lvl,
    input  logic             gr_we,
    input  logic [CNT_W-1:0] gr_wdata,
    input  logic             cnt_en,
    input  logic             flag_clr,
    input  logic             buf_mode,
    input  logic             cas_up,
    input  logic             cas_dn,
    input  logic             cas_fast,
    input  logic             rise,
    input  logic             fall,
    output logic             pin_lvl,
    output logic [CNT_W-1:0] gr,
    output logic [CNT_W-1:0] cnt,
    output logic             evt_pulse,
    output logic             evt_sticky
);
    localparam logic [CNT_W-1:0] CNT_STEP = CNT_W'(1);

    logic match, pin_cap, casc_cap, capture, event_now;

    always_comb begin
        match = is_oc && cnt_en && (cnt == gr) && !buf_mode;
        pin_cap = 1'b0;
        if (state == ST_CAP_PIN) begin
            unique case (edge_sel)
                EDGE_RISE: pin_cap = rise;
                EDGE_FALL: pin_cap = fall;
                default:   pin_cap = rise | fall;
            endcase
        end
        casc_cap  = (state == ST_CAP_CASC) && (cas_up || cas_dn) && !cas_fast;
        capture   = (pin_cap || casc_cap) && !buf_mode;
        event_now = match || capture;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt_en) begin
            cnt <= cnt + CNT_STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gr <= '0;
        end else if (capture) begin
            gr <= cnt;
        end else if (gr_we) begin
            gr <= gr_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_lvl <= 1'b0;
        end else if (init_load) begin
            pin_lvl <= init_lvl;
        end else if (match) begin
            unique case (action)
                ACT_LOW:    pin_lvl <= 1'b0;
                ACT_HIGH:   pin_lvl <= 1'b1;
                ACT_TOGGLE: pin_lvl <= ~pin_lvl;
                default:    pin_lvl <= pin_lvl;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_pulse  <= 1'b0;
            evt_sticky <= 1'b0;
        end else begin
            evt_pulse  <= event_now;
            evt_sticky <= event_now | (evt_sticky & ~flag_clr);
        end
    end

endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
    import tcc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [3:0]       cfg_wdata,
    input  logic             gr_we,
    input  logic [CNT_W-1:0] gr_wdata,
    input  logic             cnt_en,
    input  logic             flag_clr,
    input  logic             buf_mode,
    input  logic             cas_up,
    input  logic             cas_dn,
    input  logic             cas_fast,
    input  logic             pin_in,
    output logic             pin_out,
    output logic             pin_oe,
    output logic [CNT_W-1:0] gr_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             evt_pulse,
    output logic             evt_sticky
);
    tcc_state_e state;
    tcc_act_e   action;
    tcc_edge_e  edge_sel;
    logic       is_oc, oe, rise, fall;
    logic       init_load;

    assign init_load = cfg_we && !cfg_wdata[3];

    tcc_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_wdata(cfg_wdata),
        .state    (state),
        .action   (action),
        .edge_sel (edge_sel),
        .is_oc    (is_oc),
        .oe       (oe)
    );

    tcc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_in(pin_in),
        .rise  (rise),
        .fall  (fall)
    );

    tcc_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .action    (action),
        .edge_sel  (edge_sel),
        .is_oc     (is_oc),
        .init_load (init_load),
        .init_lvl  (cfg_wdata[2]),
        .gr_we     (gr_we),
        .gr_wdata  (gr_wdata),
        .cnt_en    (cnt_en),
        .flag_clr  (flag_clr),
        .buf_mode  (buf_mode),
        .cas_up    (cas_up),
        .cas_dn    (cas_dn),
        .cas_fast  (cas_fast),
        .rise      (rise),
        .fall      (fall),
        .pin_lvl   (pin_out),
        .gr        (gr_q),
        .cnt       (cnt_q),
        .evt_pulse (evt_pulse),
        .evt_sticky(evt_sticky)
    );

    assign pin_oe = oe;

endmodule

// File: rtl/tcc_channel_chk.sv
module tcc_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [3:0]       cfg_wdata,
    input logic             cnt_en,
    input logic             flag_clr,
    input logic             buf_mode,
    input logic             pin_out,
    input logic             pin_oe,
    input logic [CNT_W-1:0] cnt_q,
    input logic             evt_pulse,
    input logic             evt_sticky
);
    a_r2_init_level: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_wdata[3]) |=> (pin_out == $past(cfg_wdata[2])));

    a_r3_oe_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[3]) |=> !pin_oe);

    a_r3_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_wdata[3] && cfg_wdata[1:0] == 2'b00) |=> !pin_oe);

    a_r3_oe_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_wdata[3] && cfg_wdata[1:0] != 2'b00) |=> pin_oe);

    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    a_r5_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(cnt_q));

    a_r9_buf_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        buf_mode |=> !evt_pulse);

    a_r10_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse |-> evt_sticky);

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> (evt_sticky == evt_pulse));

endmodule

bind tcc_channel tcc_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cnt_en    (cnt_en),
    .flag_clr  (flag_clr),
    .buf_mode  (buf_mode),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .cnt_q     (cnt_q),
    .evt_pulse (evt_pulse),
    .evt_sticky(evt_sticky)
);

// File: tb/tcc_channel_test.sv
module tcc_channel_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    // {code[3:0], initial level, level after match, output enable}
    localparam logic [6:0] OC_VEC [8] = '{
        7'b0000_0_0_0, 7'b0001_0_0_1, 7'b0010_0_1_1, 7'b0011_0_1_1,
        7'b0100_1_1_0, 7'b0101_1_0_1, 7'b0110_1_1_1, 7'b0111_1_0_1
    };

    logic clk = 1'b0;
    logic rst_n, cfg_we, gr_we, cnt_en, flag_clr, buf_mode;
    logic cas_up, cas_dn, cas_fast, pin_in;
    logic [3:0] cfg_wdata;
    logic [W-1:0] gr_wdata;
    logic pin_out, pin_oe, evt_pulse, evt_sticky;
    logic [W-1:0] gr_q, cnt_q;
    logic [W-1:0] model_cnt;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcc_channel #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .gr_we(gr_we), .gr_wdata(gr_wdata), .cnt_en(cnt_en), .flag_clr(flag_clr),
        .buf_mode(buf_mode), .cas_up(cas_up), .cas_dn(cas_dn), .cas_fast(cas_fast),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .gr_q(gr_q),
        .cnt_q(cnt_q), .evt_pulse(evt_pulse), .evt_sticky(evt_sticky)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) model_cnt <= '0;
        else if (cnt_en) model_cnt <= model_cnt + 16'd1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [3:0] code);
        cfg_we = 1'b1; cfg_wdata = code;
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic write_gr(input logic [W-1:0] v);
        gr_we = 1'b1; gr_wdata = v;
        step(1);
        gr_we = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
    endtask

    task automatic cas_pulse(input logic up);
        if (up) cas_up = 1'b1; else cas_dn = 1'b1;
        step(1);
        cas_up = 1'b0; cas_dn = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] target;
        logic [W-1:0] frozen;
        int waited;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; gr_we = 1'b0; gr_wdata = '0;
        cnt_en = 1'b0; flag_clr = 1'b0; buf_mode = 1'b0; cas_up = 1'b0;
        cas_dn = 1'b0; cas_fast = 1'b0; pin_in = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        check("R1 pin_oe", pin_oe, 0);
        check("R1 pin_out", pin_out, 0);
        check("R1 gr_q", gr_q, 0);
        check("R1 cnt_q", cnt_q, 0);
        check("R1 evt_sticky", evt_sticky, 0);

        // R5 counting and holding
        cnt_en = 1'b1;
        step(10);
        cnt_en = 1'b0;
        check("R5 count", cnt_q, 10);
        step(3);
        check("R5 hold", cnt_q, 10);
        clear_flag();

        // R2/R3/R4 vector table over the output-compare codes
        for (int i = 0; i < 8; i++) begin
            write_cfg(OC_VEC[i][6:3]);
            check("R2 initial level", pin_out, OC_VEC[i][2]);
            check("R3 output enable", pin_oe, OC_VEC[i][0]);
            target = model_cnt + 16'd6;
            write_gr(target);
            clear_flag();
            cnt_en = 1'b1;
            waited = 0;
            while (!evt_pulse && waited < 40) begin
                step(1);
                waited++;
            end
            cnt_en = 1'b0;
            check("R4 match cycle", model_cnt, target + 16'd1);
            check("R4 level after match", pin_out, OC_VEC[i][1]);
            step(1);
            check("R10 pulse one cycle", evt_pulse, 0);
            check("R10 sticky held", evt_sticky, 1);
        end
        clear_flag();
        check("R10 cleared", evt_sticky, 0);

        frozen = model_cnt;

        // R6 rising-edge capture, falling ignored
        write_cfg(4'b1000);
        check("R3 capture oe", pin_oe, 0);
        write_gr(16'h1234);
        pin_in = 1'b1;
        step(4);
        check("R6 rise capture", gr_q, frozen);
        write_gr(16'h1234);
        pin_in = 1'b0;
        step(4);
        check("R6 fall ignored", gr_q, 16'h1234);

        // R6 falling-edge capture, rising ignored
        write_cfg(4'b1001);
        pin_in = 1'b1;
        step(4);
        check("R6 rise ignored", gr_q, 16'h1234);
        pin_in = 1'b0;
        step(4);
        check("R6 fall capture", gr_q, frozen);

        // R7 both edges
        write_cfg(4'b1010);
        write_gr(16'h1234);
        pin_in = 1'b1;
        step(4);
        check("R7 rise capture", gr_q, frozen);
        write_gr(16'h1234);
        pin_in = 1'b0;
        step(4);
        check("R7 fall capture", gr_q, frozen);

        // R8 cascaded capture
        write_cfg(4'b1100);
        write_gr(16'h1234);
        pin_in = 1'b1;
        step(4);
        pin_in = 1'b0;
        step(4);
        check("R8 pin ignored", gr_q, 16'h1234);
        cas_pulse(1'b0);
        check("R8 down-count capture", gr_q, frozen);
        write_gr(16'h1234);
        cas_fast = 1'b1;
        clear_flag();
        cas_pulse(1'b1);
        cas_fast = 1'b0;
        check("R8 fast clock blocks", gr_q, 16'h1234);
        check("R8 fast clock no flag", evt_sticky, 0);

        // R9 buffer mode suppresses capture and compare
        buf_mode = 1'b1;
        cas_pulse(1'b1);
        check("R9 no capture", gr_q, 16'h1234);
        check("R9 no capture flag", evt_sticky, 0);
        write_cfg(4'b0011);
        write_gr(model_cnt + 16'd3);
        cnt_en = 1'b1;
        step(8);
        cnt_en = 1'b0;
        check("R9 pin unchanged", pin_out, 0);
        check("R9 no match flag", evt_sticky, 0);
        buf_mode = 1'b0;

        // R11 capture beats software write
        write_cfg(4'b1100);
        frozen = model_cnt;
        gr_we = 1'b1; gr_wdata = 16'hBEEF; cas_up = 1'b1;
        step(1);
        gr_we = 1'b0; cas_up = 1'b0;
        check("R11 capture priority", gr_q, frozen);

        // R10 new event wins over clear in the same cycle
        clear_flag();
        flag_clr = 1'b1; cas_up = 1'b1;
        step(1);
        flag_clr = 1'b0; cas_up = 1'b0;
        check("R10 set beats clear", evt_sticky, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule